// File: doc/BRIEF.md
# ROM and RAM Memory Subsystem Decoder

This block is the memory end of a small processor bus with a 20-bit address, already separated from any shared address/data lines, and an 8-bit data path. It contains an 8 KB read-only region that answers at the top of the address space and an 8 KB read/write region that answers at the bottom. It produces an active-low select for each region from the address and the active-low memory read and write commands. It returns read data and takes write data itself.

A mode input chooses how much of the address is compared. With full decoding, the seven bits above the 13-bit in-region offset must be all ones for the ROM or all zeros for the RAM. Every other address selects nothing, and the read data is not driven. With partial decoding, only 14 address lines take part. Bit 13 alone picks the region, so each region repeats throughout the whole space.

The ROM contents are a fixed pattern computed from the offset. RAM writes are taken on the rising edge of the write strobe, as seen by the block clock. Read data is combinational from the address while the read command is low.

Top module: `mem_sub_decoder`

## Requirements
- R1: With partial_mode low and addr[19:13] all ones, a low rd_n or wr_n pulls rom_cs_n low. A read there returns the ROM byte for offset o = addr[12:0], defined as o[7:0] XOR {o[12:8], 3'b101}.
- R2: With partial_mode low and addr[19:13] all zeros, a low rd_n or wr_n pulls ram_cs_n low. A read returns the byte stored at offset addr[12:0].
- R3: With partial_mode low and any other addr[19:13] value, both selects stay high, rdata_oe stays low and rdata is 0, even with a command active.
- R4: With partial_mode high, addr[13]=1 selects the ROM and addr[13]=0 selects the RAM. addr[19:14] has no effect on the select or on the data.
- R5: While rd_n and wr_n are both high, rom_cs_n and ram_cs_n are both high.
- R6: A RAM write lands on the first clk rising edge that samples wr_n high after it was sampled low. It uses the offset and wdata last sampled while wr_n was low, and a read in the next cycle returns the new byte.
- R7: A write to a ROM address or to an unmapped address changes no RAM byte and leaves the ROM data unchanged.
- R8: rdata_oe is high only while rd_n is low and one region is selected. Otherwise rdata is 0.
- R9: rom_cs_n and ram_cs_n are never low at the same time.
- R10: During and right after reset, with the commands high, both selects are high and rdata_oe is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock that samples the write strobe |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 20 | Memory address |
| rd_n | input | 1 | Active-low memory read command |
| wr_n | input | 1 | Active-low memory write command |
| partial_mode | input | 1 | 1 = bit 13 picks the region, 0 = full decoding |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, 0 when not driven |
| rdata_oe | output | 1 | High while rdata is driven |
| rom_cs_n | output | 1 | Active-low ROM select |
| ram_cs_n | output | 1 | Active-low RAM select |

## Verification
The selects, rdata and rdata_oe follow the address, mode and commands with no register in the path. The bench therefore drives inputs on the falling clock edge and checks these outputs 1 ns later, within the same cycle. A write needs one rising edge to sample wr_n high after it was low. So the bench raises wr_n on a falling edge, waits for the next rising edge, and reads the location back only from the following falling edge on. The bench keeps its own byte model and applies each write to it at that same rising edge.

// File: rtl/mem_sub_decoder.sv
`timescale 1ns/1ps
module mem_sub_decoder #(
  parameter int ADDR_W = 20,
  parameter int OFF_W  = 13,
  parameter int DATA_W = 8,
  parameter int LANES  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              rd_n,
  input  logic              wr_n,
  input  logic              partial_mode,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              rdata_oe,
  output logic              rom_cs_n,
  output logic              ram_cs_n
);
  localparam int TAG_W   = ADDR_W - OFF_W;
  localparam int LANE_W  = $clog2(LANES);
  localparam int WORD_AW = OFF_W - LANE_W;
  localparam int DEPTH   = 1 << WORD_AW;
  localparam int WORD_W  = LANES * DATA_W;

  logic [OFF_W-1:0] off;
  logic [TAG_W-1:0] tag;
  logic             cmd, rom_hit, ram_hit;

  assign off     = addr[OFF_W-1:0];
  assign tag     = addr[ADDR_W-1:OFF_W];
  assign cmd     = !rd_n || !wr_n;
  assign rom_hit = partial_mode ?  addr[OFF_W] : (&tag);
  assign ram_hit = partial_mode ? !addr[OFF_W] : ~(|tag);
  assign rom_cs_n = !(cmd && rom_hit);
  assign ram_cs_n = !(cmd && ram_hit);

  logic [WORD_W-1:0] ram [DEPTH];
  logic [WORD_W-1:0] ram_word;
  logic [DATA_W-1:0] ram_byte, rom_byte;

  assign ram_word = ram[off[OFF_W-1:LANE_W]];
  assign ram_byte = ram_word[off[LANE_W-1:0]*DATA_W +: DATA_W];
  assign rom_byte = off[DATA_W-1:0] ^ DATA_W'({off >> DATA_W, 3'b101});

  assign rdata_oe = !rd_n && !(rom_cs_n && ram_cs_n);
  assign rdata    = !rdata_oe ? '0 : (!rom_cs_n ? rom_byte : ram_byte);

  logic              wr_q, pend_ram, commit;
  logic [OFF_W-1:0]  pend_off;
  logic [DATA_W-1:0] pend_data;

  assign commit = !wr_q && wr_n && pend_ram;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q      <= 1'b1;
      pend_ram  <= 1'b0;
      pend_off  <= '0;
      pend_data <= '0;
    end else begin
      wr_q <= wr_n;
      if (!wr_n) begin
        pend_ram  <= !ram_cs_n;
        pend_off  <= off;
        pend_data <= wdata;
      end
    end
  end

  always_ff @(posedge clk) begin
    for (int g = 0; g < LANES; g++)
      if (commit && pend_off[LANE_W-1:0] == LANE_W'(g))
        ram[pend_off[OFF_W-1:LANE_W]][g*DATA_W +: DATA_W] <= pend_data;
  end

  logic              chk_v;
  logic [OFF_W-1:0]  chk_off;
  logic [DATA_W-1:0] chk_data;
  logic [WORD_W-1:0] chk_word;
  logic [DATA_W-1:0] chk_byte;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chk_v    <= 1'b0;
      chk_off  <= '0;
      chk_data <= '0;
    end else begin
      chk_v    <= commit;
      chk_off  <= pend_off;
      chk_data <= pend_data;
    end
  end

  assign chk_word = ram[chk_off[OFF_W-1:LANE_W]];
  assign chk_byte = chk_word[chk_off[LANE_W-1:0]*DATA_W +: DATA_W];

  AST_ONE_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
    !(!rom_cs_n && !ram_cs_n)); // R9
  AST_SEL_NEEDS_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    (!rom_cs_n || !ram_cs_n) |-> (!rd_n || !wr_n)); // R5
  AST_FULL_ROM_TAG: assert property (@(posedge clk) disable iff (!rst_n)
    (!partial_mode && !rom_cs_n) |-> (&addr[ADDR_W-1:OFF_W])); // R1
  AST_FULL_RAM_TAG: assert property (@(posedge clk) disable iff (!rst_n)
    (!partial_mode && !ram_cs_n) |-> (addr[ADDR_W-1:OFF_W] == '0)); // R2
  AST_OE_ONLY_READ: assert property (@(posedge clk) disable iff (!rst_n)
    rdata_oe |-> !rd_n); // R8
  AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    chk_v |-> (chk_byte == chk_data)); // R6
endmodule

// File: tb/tb_mem_sub_decoder.sv
`timescale 1ns/1ps
module tb_mem_sub_decoder;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [19:0] addr = '0;
  logic        rd_n = 1'b1, wr_n = 1'b1, partial_mode = 1'b0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  logic        rdata_oe, rom_cs_n, ram_cs_n;

  always #2 clk = ~clk;

  mem_sub_decoder dut (.clk(clk), .rst_n(rst_n), .addr(addr), .rd_n(rd_n), .wr_n(wr_n),
    .partial_mode(partial_mode), .wdata(wdata), .rdata(rdata), .rdata_oe(rdata_oe),
    .rom_cs_n(rom_cs_n), .ram_cs_n(ram_cs_n));

  int  total = 0, bad = 0;
  bit  done = 0;
  logic [31:0] model [2048];

  function automatic int target(logic [19:0] a, bit p);
    if (p) return a[13] ? 1 : 2;
    if (&a[19:13]) return 1;
    if (a[19:13] == 7'd0) return 2;
    return 0;
  endfunction

  function automatic logic [7:0] rom_pat(logic [12:0] o);
    return o[7:0] ^ {o[12:8], 3'b101};
  endfunction

  function automatic logic [7:0] mget(logic [12:0] o);
    return model[o[12:2]][o[1:0]*8 +: 8];
  endfunction

  task automatic check(string req, string what, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic check_sel(string req, int t);
    check(req, "rom_cs_n", int'(rom_cs_n), (t == 1) ? 0 : 1);
    check(req, "ram_cs_n", int'(ram_cs_n), (t == 2) ? 0 : 1);
    check("R9", "both selects low", int'(!rom_cs_n && !ram_cs_n), 0);
  endtask

  task automatic do_read(logic [19:0] a, bit p, string req);
    int t = target(a, p);
    logic [7:0] e = (t == 1) ? rom_pat(a[12:0]) : (t == 2) ? mget(a[12:0]) : 8'h00;
    @(negedge clk);
    addr = a; partial_mode = p; rd_n = 1'b0;
    #1;
    check_sel(req, t);
    check(req, "rdata_oe", int'(rdata_oe), (t != 0) ? 1 : 0);
    check(req, "rdata", int'(rdata), int'(e));
    @(negedge clk);
    rd_n = 1'b1;
  endtask

  task automatic do_write(logic [19:0] a, logic [7:0] d, bit p, string req);
    int t = target(a, p);
    @(negedge clk);
    addr = a; partial_mode = p; wdata = d; wr_n = 1'b0;
    #1;
    check_sel(req, t);
    check("R8", "rdata_oe on write", int'(rdata_oe), 0);
    check("R8", "rdata on write", int'(rdata), 0);
    @(negedge clk);
    wr_n = 1'b1;
    @(posedge clk);
    if (t == 2) model[a[12:2]][a[1:0]*8 +: 8] = d;
  endtask

  initial begin
    void'($urandom(32'd1357));
    #1;
    check("R10", "rom_cs_n in reset", int'(rom_cs_n), 1);
    check("R10", "ram_cs_n in reset", int'(ram_cs_n), 1);
    check("R10", "rdata_oe in reset", int'(rdata_oe), 0);
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    #1;
    check("R10", "rom_cs_n after reset", int'(rom_cs_n), 1);
    check("R10", "ram_cs_n after reset", int'(ram_cs_n), 1);

    for (int o = 0; o < 8192; o++)
      do_write(20'(o), 8'($urandom), 1'b0, "R2");

    do_read(20'hFE000, 0, "R1");
    do_read(20'hFFFFF, 0, "R1");
    do_read(20'h00000, 0, "R2");
    do_read(20'h01FFF, 0, "R2");
    do_read(20'h02000, 0, "R3");
    do_read(20'hFDFFF, 0, "R3");
    do_read(20'h40123, 0, "R3");

    @(negedge clk); addr = 20'hFE010; partial_mode = 0; #1;
    check_sel("R5", 0);
    check("R8", "rdata idle", int'(rdata), 0);

    do_read(20'hA2345, 1, "R4");
    do_read(20'h5C345, 1, "R4");
    do_read(20'hA0345, 1, "R4");
    do_read(20'h3E345, 1, "R4");

    do_write(20'hFE055, 8'hC3, 0, "R7");
    do_read(20'h00055, 0, "R7");
    do_read(20'hFE055, 0, "R7");
    do_write(20'h60055, 8'h3C, 0, "R7");
    do_read(20'h00055, 0, "R7");
    do_write(20'h7E055, 8'h99, 1, "R7");
    do_read(20'h00055, 0, "R7");

    @(negedge clk);
    addr = 20'h00321; partial_mode = 0; wdata = 8'h11; wr_n = 1'b0;
    @(negedge clk); wdata = 8'h77;
    @(negedge clk); wr_n = 1'b1;
    @(posedge clk);
    @(negedge clk); rd_n = 1'b0; #1;
    check("R6", "last sampled wdata", int'(rdata), 8'h77);
    model[20'h00321 >> 2][1*8 +: 8] = 8'h77;
    @(negedge clk); rd_n = 1'b1;
    do_write(20'hB1234, 8'h5A, 1, "R6");
    do_read(20'h01234, 0, "R6");

    for (int i = 0; i < 3000; i++) begin
      int k = int'($urandom % 4);
      bit p = 1'($urandom);
      logic [19:0] a = 20'($urandom);
      if (!p && k == 0) a[19:13] = 7'h7F;
      if (!p && k == 1) a[19:13] = 7'h00;
      if ($urandom % 2 == 0) do_read(a, p, "R4");
      else do_write(a, 8'($urandom), p, "R7");
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog run did not finish actual=0 expected=1");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule